// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer

This block runs one read or one write at a time against an external asynchronous memory or peripheral. A request enters through a valid/ready command port that carries the direction, the address and the write data. Each access then passes through three timed phases: setup, pulse and hold. Every phase length is programmable, and when the access ends the block raises a one-cycle completion pulse together with the read data.

For each direction, a mode bit chooses the controlling signal. That signal is low only during the pulse phase, while the other signal of the pair stays low for the whole access. The choice is between the dedicated strobe and the chip select. A wait input from the device can freeze the access in the middle of the pulse, or it can hold the pulse open at its last cycle until the device is ready.

After a read, a programmable number of turnaround cycles keeps the bus from being driven again. In the default setting these cycles hold off the next request. With folding enabled they are absorbed into the setup phase of the next access. All timing settings are captured when a request is accepted, so the inputs may change freely while an access is running.

Top module: `mem_seq_top`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high, the data drive enable and done are low, and the port reports ready.
- R2: For a read with the read-control bit at 1, chip select is low for every setup, pulse and hold cycle, and the read strobe is low only for the pulse cycles.
- R3: For a read with the read-control bit at 0, the read strobe is low for the whole access, and chip select is low only for the pulse cycles.
- R4: The write-control bit selects the controlling signal for writes in the same way (1 = write strobe, 0 = chip select). The read and write strobes are never low together.
- R5: A setup count of 0 skips the setup phase. A hold count of 0 skips the hold phase when wait is disabled. A pulse count of 0 behaves as 1.
- R6: A wait-mode field value of 00 (off) or 01 (reserved) leaves every output independent of the wait input.
- R7: In wait mode 10 (freeze), every pulse cycle in which the wait input is sampled low adds one cycle to the pulse, and the access then resumes where it left off.
- R8: In wait mode 11 (ready), the wait input is looked at only in the last pulse cycle. While it is low there, the pulse is held, and it ends at the first edge where it is high.
- R9: The wait input has no effect during setup or hold in any mode.
- R10: When the wait mode is 10 or 11, a hold count of 0 is run as a 1-cycle hold.
- R11: After a read's controlling signal rises, the bus is kept free for the turnaround count of cycles. With folding off, ready stays low until those cycles have passed.
- R12: With folding on, ready does not wait for turnaround. Instead the next access stays in setup until turnaround has run out, and the write data enable stays low while turnaround is pending.
- R13: Done is high for exactly the one cycle after the last cycle of an access. For reads, the read data holds the data input sampled at the clock edge that ends the pulse.
- R14: A request is accepted only when the sequencer is idle. Address, write data and timing settings are captured at acceptance, and changes to them afterwards do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Command accepted when high with req_valid |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| cfg_setup | input | 6 | Setup cycles |
| cfg_pulse | input | 6 | Pulse cycles |
| cfg_hold | input | 6 | Hold cycles |
| cfg_float | input | 4 | Turnaround cycles after a read |
| cfg_float_fold | input | 1 | Fold turnaround into next setup |
| cfg_rd_strobe_ctl | input | 1 | Read controlled by strobe (1) or chip select (0) |
| cfg_wr_strobe_ctl | input | 1 | Write controlled by strobe (1) or chip select (0) |
| cfg_wait_mode | input | 2 | 00 off, 01 reserved, 10 freeze, 11 ready |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_oe | output | 1 | Write data drive enable |
| mem_addr | output | ADDR_W | Address to the device |
| mem_dout | output | DATA_W | Write data to the device |
| mem_din | input | DATA_W | Read data from the device |
| mem_wait_n | input | 1 | Device wait, low = wait |

## Verification
Reads and writes are issued under both choices of controlling signal, with nonzero phase lengths and with all-zero phase lengths. These runs separate the whole-access signal from the pulse-only signal, and they show whether the zero-length rules are honored. A wait input that switches low in a fixed irregular pattern is applied in every wait mode. Under that pattern, the reserved code must match the off code, freeze must stretch the pulse at each low sample, and ready mode must react only in the final pulse cycle. Back-to-back read-then-write pairs, run with folding off and with folding on, distinguish turnaround that holds off acceptance from turnaround that stretches the next setup. Setting changes made during an access check that values are captured at acceptance.

// File: rtl/mem_seq_pkg.sv
`timescale 1ns/1ps
package mem_seq_pkg;

    localparam int CNT_W = 6;
    localparam int FLT_W = 4;

    typedef enum logic [1:0] {
        WT_OFF    = 2'b00,
        WT_RSVD   = 2'b01,
        WT_FREEZE = 2'b10,
        WT_READY  = 2'b11
    } wait_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] pulse;
        logic [CNT_W-1:0] hold;
        logic [FLT_W-1:0] flt;
        logic             rd_by_strobe;
        logic             wr_by_strobe;
        wait_mode_e       wmode;
    } timing_t;

    function automatic logic wait_enabled(wait_mode_e m);
        return (m == WT_FREEZE) || (m == WT_READY);
    endfunction

    // Pulse of zero becomes one; hold of zero becomes one when wait is in use.
    function automatic timing_t sanitize(timing_t t);
        timing_t s;
        s = t;
        if (s.pulse == '0) s.pulse = CNT_W'(1);
        if (wait_enabled(s.wmode) && (s.hold == '0)) s.hold = CNT_W'(1);
        return s;
    endfunction

    // True when the cycle now running is the last one of a phase of length len.
    function automatic logic reached(logic [CNT_W-1:0] cnt, logic [CNT_W-1:0] len);
        return ((CNT_W+1)'(cnt) + (CNT_W+1)'(1)) >= (CNT_W+1)'(len);
    endfunction

endpackage

// File: rtl/mem_seq_float.sv
`timescale 1ns/1ps
module mem_seq_float
    import mem_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [FLT_W-1:0] load_val,
    output logic [FLT_W-1:0] flo_q,
    output logic [FLT_W-1:0] flo_d
);
    always_comb begin
        if (load)              flo_d = load_val;
        else if (flo_q != '0)  flo_d = flo_q - FLT_W'(1);
        else                   flo_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flo_q <= '0;
        else     flo_q <= flo_d;
    end
endmodule

// File: rtl/mem_seq_phase.sv
`timescale 1ns/1ps
module mem_seq_phase
    import mem_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] setup,
    input  logic [CNT_W-1:0] pulse,
    input  logic [CNT_W-1:0] hold,
    input  wait_mode_e       wmode,
    input  logic [FLT_W-1:0] flo_q,
    input  logic             wait_n,
    output phase_e           phase_q,
    output phase_e           phase_d,
    output logic             pulse_end
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pulse_last;
    logic             frozen;
    logic             not_ready;
    logic             flo_clear;

    always_comb begin
        phase_d    = phase_q;
        cnt_d      = cnt_q;
        pulse_end  = 1'b0;
        pulse_last = reached(cnt_q, pulse);
        frozen     = (wmode == WT_FREEZE) && !wait_n;
        not_ready  = (wmode == WT_READY) && pulse_last && !wait_n;
        flo_clear  = (flo_q <= FLT_W'(1));
        case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    cnt_d   = '0;
                    phase_d = ((setup == '0) && flo_clear) ? PH_PULSE : PH_SETUP;
                end
            end
            PH_SETUP: begin
                if (reached(cnt_q, setup) && flo_clear) begin
                    cnt_d   = '0;
                    phase_d = PH_PULSE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            PH_PULSE: begin
                if (!(frozen || not_ready)) begin
                    if (pulse_last) begin
                        pulse_end = 1'b1;
                        cnt_d     = '0;
                        phase_d   = (hold == '0) ? PH_IDLE : PH_HOLD;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: begin
                if (reached(cnt_q, hold)) begin
                    cnt_d   = '0;
                    phase_d = PH_IDLE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/mem_seq_pins.sv
`timescale 1ns/1ps
module mem_seq_pins
    import mem_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase_d,
    input  logic             is_write,
    input  logic             rd_by_strobe,
    input  logic             wr_by_strobe,
    input  logic [FLT_W-1:0] flo_d,
    output logic             cs_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic             oe
);
    logic active, in_pulse, by_strobe;
    logic cs_low, strobe_low;

    always_comb begin
        active     = (phase_d != PH_IDLE);
        in_pulse   = (phase_d == PH_PULSE);
        by_strobe  = is_write ? wr_by_strobe : rd_by_strobe;
        cs_low     = by_strobe ? active : in_pulse;
        strobe_low = by_strobe ? in_pulse : active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n <= 1'b1;
            rd_n <= 1'b1;
            wr_n <= 1'b1;
            oe   <= 1'b0;
        end else begin
            cs_n <= !cs_low;
            rd_n <= !(strobe_low && !is_write);
            wr_n <= !(strobe_low && is_write);
            oe   <= is_write && active && (flo_d == '0);
        end
    end
endmodule

// File: rtl/mem_seq_top.sv
`timescale 1ns/1ps
module mem_seq_top
    import mem_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [5:0]        cfg_setup,
    input  logic [5:0]        cfg_pulse,
    input  logic [5:0]        cfg_hold,
    input  logic [3:0]        cfg_float,
    input  logic              cfg_float_fold,
    input  logic              cfg_rd_strobe_ctl,
    input  logic              cfg_wr_strobe_ctl,
    input  logic [1:0]        cfg_wait_mode,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              mem_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    input  logic              mem_wait_n
);
    timing_t          tm_new, tm_q, tm_cur;
    logic             wr_q, wr_cur;
    logic             accept;
    logic             pulse_end;
    phase_e           phase_q, phase_d;
    logic [FLT_W-1:0] flo_q, flo_d;

    always_comb begin
        tm_new = sanitize('{setup:        cfg_setup,
                            pulse:        cfg_pulse,
                            hold:         cfg_hold,
                            flt:          cfg_float,
                            rd_by_strobe: cfg_rd_strobe_ctl,
                            wr_by_strobe: cfg_wr_strobe_ctl,
                            wmode:        wait_mode_e'(cfg_wait_mode)});
    end

    assign req_ready = (phase_q == PH_IDLE) && (cfg_float_fold || (flo_q == '0));
    assign accept    = req_valid && req_ready;
    assign tm_cur    = accept ? tm_new : tm_q;
    assign wr_cur    = accept ? req_write : wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q      <= '0;
            wr_q      <= 1'b0;
            mem_addr  <= '0;
            mem_dout  <= '0;
            rsp_rdata <= '0;
            rsp_done  <= 1'b0;
        end else begin
            if (accept) begin
                tm_q     <= tm_new;
                wr_q     <= req_write;
                mem_addr <= req_addr;
                mem_dout <= req_wdata;
            end
            if (pulse_end && !wr_q) rsp_rdata <= mem_din;
            rsp_done <= (phase_q != PH_IDLE) && (phase_d == PH_IDLE);
        end
    end

    mem_seq_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .setup     (tm_cur.setup),
        .pulse     (tm_cur.pulse),
        .hold      (tm_cur.hold),
        .wmode     (tm_cur.wmode),
        .flo_q     (flo_q),
        .wait_n    (mem_wait_n),
        .phase_q   (phase_q),
        .phase_d   (phase_d),
        .pulse_end (pulse_end)
    );

    mem_seq_float u_float (
        .clk      (clk),
        .rst      (rst),
        .load     (pulse_end && !wr_q),
        .load_val (tm_cur.flt),
        .flo_q    (flo_q),
        .flo_d    (flo_d)
    );

    mem_seq_pins u_pins (
        .clk          (clk),
        .rst          (rst),
        .phase_d      (phase_d),
        .is_write     (wr_cur),
        .rd_by_strobe (tm_cur.rd_by_strobe),
        .wr_by_strobe (tm_cur.wr_by_strobe),
        .flo_d        (flo_d),
        .cs_n         (mem_cs_n),
        .rd_n         (mem_rd_n),
        .wr_n         (mem_wr_n),
        .oe           (mem_oe)
    );
endmodule

// File: rtl/mem_seq_checks.sv
`timescale 1ns/1ps
module mem_seq_checks #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              mem_cs_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic              mem_oe,
    input logic [ADDR_W-1:0] mem_addr
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (mem_cs_n && mem_rd_n && mem_wr_n && !mem_oe && !rsp_done));

    p_strobes_apart_r4: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n));

    p_done_single_r13: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_done_follows_access_r13: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(!mem_cs_n || !mem_rd_n || !mem_wr_n));

    p_ready_when_quiet_r14: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_rd_n && mem_wr_n && !mem_oe));

    p_addr_held_r14: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    p_no_drive_on_read_r12: assert property (@(posedge clk) disable iff (rst)
        mem_oe |-> mem_rd_n);
endmodule

bind mem_seq_top mem_seq_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_oe    (mem_oe),
    .mem_addr  (mem_addr)
);

// File: tb/mem_seq_top_test.sv
`timescale 1ns/1ps
module mem_seq_top_test;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [5:0]    cfg_setup = 6'd0;
    logic [5:0]    cfg_pulse = 6'd1;
    logic [5:0]    cfg_hold = 6'd0;
    logic [3:0]    cfg_float = 4'd0;
    logic          cfg_float_fold = 1'b0;
    logic          cfg_rd_strobe_ctl = 1'b1;
    logic          cfg_wr_strobe_ctl = 1'b1;
    logic [1:0]    cfg_wait_mode = 2'b00;
    logic          mem_cs_n, mem_rd_n, mem_wr_n, mem_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout;
    logic [DW-1:0] mem_din = '0;
    logic          mem_wait_n = 1'b1;

    mem_seq_top #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
        .cfg_float(cfg_float), .cfg_float_fold(cfg_float_fold),
        .cfg_rd_strobe_ctl(cfg_rd_strobe_ctl), .cfg_wr_strobe_ctl(cfg_wr_strobe_ctl),
        .cfg_wait_mode(cfg_wait_mode),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_oe(mem_oe), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_din(mem_din), .mem_wait_n(mem_wait_n)
    );

    always #2.5 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    wd = 0;
    int    tick = 0;
    int    wait_src = 0;
    bit    finished = 0;
    string cur_req = "R1 reset state";

    // Device side: data input changes every cycle, wait follows an irregular pattern.
    always @(posedge clk) begin
        #1;
        tick = tick + 1;
        mem_din = DW'(tick * 41 + 7);
        if (wait_src == 0) mem_wait_n = 1'b1;
        else               mem_wait_n = (((tick * 5) + (tick / 3)) % 4) != 0;
    end

    // Behavioural reference: phases as countdowns of remaining cycles.
    int            m_ms, m_rem, m_flo, m_setup, m_pulse, m_hold, m_flt, m_wm, nflo;
    bit            m_wr, m_rdstb, m_wrstb, acc, fin, act, pul, stall;
    logic          e_cs, e_rd, e_wr, e_oe, e_done;
    logic [DW-1:0] e_rdata, e_dout;
    logic [AW-1:0] e_addr;

    always @(posedge clk) begin
        if (rst) begin
            m_ms = 0; m_rem = 0; m_flo = 0; m_wr = 0; m_rdstb = 0; m_wrstb = 0;
            e_done = 0; e_rdata = '0; e_addr = '0; e_dout = '0;
        end else begin
            acc  = req_valid && (m_ms == 0) && (cfg_float_fold || m_flo == 0);
            nflo = (m_flo > 0) ? m_flo - 1 : 0;
            fin  = 0;
            case (m_ms)
                0: if (acc) begin
                    m_wr    = req_write;
                    m_rdstb = cfg_rd_strobe_ctl;
                    m_wrstb = cfg_wr_strobe_ctl;
                    m_wm    = int'(cfg_wait_mode);
                    m_setup = int'(cfg_setup);
                    m_pulse = (cfg_pulse == 0) ? 1 : int'(cfg_pulse);
                    m_hold  = (cfg_wait_mode[1] && cfg_hold == 0) ? 1 : int'(cfg_hold);
                    m_flt   = int'(cfg_float);
                    e_addr  = req_addr;
                    e_dout  = req_wdata;
                    if (m_setup == 0 && m_flo <= 1) begin m_ms = 2; m_rem = m_pulse; end
                    else begin m_ms = 1; m_rem = m_setup; end
                end
                1: begin
                    m_rem = m_rem - 1;
                    if (m_rem <= 0 && m_flo <= 1) begin m_ms = 2; m_rem = m_pulse; end
                end
                2: begin
                    stall = (m_wm == 2 && !mem_wait_n) || (m_wm == 3 && m_rem == 1 && !mem_wait_n);
                    if (!stall) begin
                        m_rem = m_rem - 1;
                        if (m_rem == 0) begin
                            if (!m_wr) begin e_rdata = mem_din; nflo = m_flt; end
                            if (m_hold == 0) begin m_ms = 0; fin = 1; end
                            else begin m_ms = 3; m_rem = m_hold; end
                        end
                    end
                end
                default: begin
                    m_rem = m_rem - 1;
                    if (m_rem == 0) begin m_ms = 0; fin = 1; end
                end
            endcase
            m_flo  = nflo;
            e_done = fin;
        end
        act = (m_ms != 0);
        pul = (m_ms == 2);
        if (m_wr) begin
            e_rd = 1'b1;
            e_cs = m_wrstb ? !act : !pul;
            e_wr = m_wrstb ? !pul : !act;
        end else begin
            e_wr = 1'b1;
            e_cs = m_rdstb ? !act : !pul;
            e_rd = m_rdstb ? !pul : !act;
        end
        e_oe = m_wr && act && (m_flo == 0);
    end

    task automatic chk(input string sig, input logic [31:0] actual, input logic [31:0] expect_v);
        n_cmp = n_cmp + 1;
        if (actual !== expect_v) begin
            n_bad = n_bad + 1;
            $display("FAIL %s [%s]: actual %0h expected %0h at %0t", cur_req, sig, actual, expect_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("cs_n",  32'(mem_cs_n),  32'(e_cs));
            chk("rd_n",  32'(mem_rd_n),  32'(e_rd));
            chk("wr_n",  32'(mem_wr_n),  32'(e_wr));
            chk("oe",    32'(mem_oe),    32'(e_oe));
            chk("done",  32'(rsp_done),  32'(e_done));
            chk("ready", 32'(req_ready), 32'((m_ms == 0) && (cfg_float_fold || m_flo == 0)));
            chk("rdata", 32'(rsp_rdata), 32'(e_rdata));
            chk("addr",  32'(mem_addr),  32'(e_addr));
            chk("dout",  32'(mem_dout),  32'(e_dout));
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000 && !finished) begin
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL %s [watchdog]: actual hung expected completion", cur_req);
            summary();
        end
    end

    task automatic set_cfg(input int s, input int p, input int h, input int f,
                           input bit fold, input bit rdm, input bit wrm, input int wm);
        cfg_setup = 6'(s); cfg_pulse = 6'(p); cfg_hold = 6'(h); cfg_float = 4'(f);
        cfg_float_fold = fold; cfg_rd_strobe_ctl = rdm; cfg_wr_strobe_ctl = wrm;
        cfg_wait_mode = 2'(wm);
    endtask

    // Present a request and return just after the edge that accepts it.
    task automatic do_acc(input bit wr, input int addr, input int data);
        bit seen;
        req_write = wr; req_addr = AW'(addr); req_wdata = DW'(data); req_valid = 1'b1;
        forever begin
            @(negedge clk);
            seen = req_ready;
            @(posedge clk);
            #1;
            if (seen) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        forever begin
            @(negedge clk);
            if (m_ms == 0 && (cfg_float_fold || m_flo == 0)) break;
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        cur_req = "R1 reset state";
        repeat (3) @(posedge clk);
        #1;

        cur_req = "R2 read, strobe controls";
        set_cfg(2, 3, 2, 0, 0, 1, 1, 0);
        do_acc(0, 16'h0101, 0); wait_idle();
        do_acc(0, 16'h0102, 0); wait_idle();

        cur_req = "R3 read, chip select controls";
        set_cfg(1, 4, 3, 0, 0, 0, 1, 0);
        do_acc(0, 16'h0203, 0); wait_idle();

        cur_req = "R4 write, both control choices";
        set_cfg(2, 2, 1, 0, 0, 1, 1, 0);
        do_acc(1, 16'h0304, 16'hBEEF); wait_idle();
        set_cfg(1, 3, 2, 0, 0, 1, 0, 0);
        do_acc(1, 16'h0305, 16'h1234); wait_idle();

        cur_req = "R5 zero-length phases";
        set_cfg(0, 0, 0, 0, 0, 1, 1, 0);
        do_acc(0, 16'h0406, 0); do_acc(1, 16'h0407, 16'h5A5A); wait_idle();
        set_cfg(0, 2, 0, 0, 0, 0, 0, 0);
        do_acc(1, 16'h0408, 16'h0F0F); wait_idle();

        cur_req = "R6 wait off and reserved ignored";
        wait_src = 1;
        set_cfg(1, 4, 1, 0, 0, 1, 1, 0);
        do_acc(0, 16'h0509, 0); do_acc(1, 16'h050A, 16'hAAAA); wait_idle();
        set_cfg(1, 4, 0, 0, 0, 0, 1, 1);
        do_acc(0, 16'h050B, 0); do_acc(1, 16'h050C, 16'h5555); wait_idle();

        cur_req = "R7 freeze wait";
        set_cfg(2, 5, 2, 0, 0, 1, 1, 2);
        for (int i = 0; i < 4; i++) begin
            do_acc(i % 2 == 1, 16'h0600 + i, 16'h6000 + i);
            wait_idle();
        end

        cur_req = "R8 ready wait";
        set_cfg(1, 3, 2, 0, 0, 1, 0, 3);
        for (int i = 0; i < 4; i++) begin
            do_acc(i % 2 == 0, 16'h0700 + i, 16'h7000 + i);
            wait_idle();
        end

        cur_req = "R9 wait in setup and hold";
        set_cfg(6, 1, 6, 0, 0, 0, 1, 2);
        do_acc(0, 16'h0801, 0); wait_idle();
        set_cfg(6, 1, 6, 0, 0, 1, 1, 3);
        do_acc(1, 16'h0802, 16'h8888); wait_idle();

        cur_req = "R10 hold forced with wait";
        set_cfg(0, 2, 0, 0, 0, 1, 1, 2);
        do_acc(0, 16'h0901, 0); do_acc(1, 16'h0902, 16'h9999); wait_idle();
        set_cfg(1, 1, 0, 0, 0, 0, 0, 3);
        do_acc(0, 16'h0903, 0); wait_idle();
        wait_src = 0;

        cur_req = "R11 turnaround blocks next request";
        set_cfg(1, 2, 1, 5, 0, 1, 1, 0);
        do_acc(0, 16'h0A01, 0); do_acc(1, 16'h0A02, 16'hA0A0); wait_idle();
        set_cfg(0, 1, 0, 9, 0, 0, 1, 0);
        do_acc(0, 16'h0A03, 0); do_acc(0, 16'h0A04, 0); wait_idle();

        cur_req = "R12 turnaround folded into setup";
        set_cfg(1, 2, 1, 6, 1, 1, 1, 0);
        do_acc(0, 16'h0B01, 0); do_acc(1, 16'h0B02, 16'hB0B0);
        do_acc(0, 16'h0B03, 0); wait_idle();
        set_cfg(0, 1, 0, 4, 1, 1, 1, 0);
        do_acc(0, 16'h0B04, 0); do_acc(1, 16'h0B05, 16'hB1B1); wait_idle();

        cur_req = "R13 done pulse and read capture";
        for (int i = 1; i < 6; i++) begin
            set_cfg(i % 3, i, 5 - i, 0, 0, i % 2 == 0, 1, 0);
            do_acc(0, 16'h0C00 + i, 0);
            wait_idle();
        end

        cur_req = "R14 inputs captured at acceptance";
        set_cfg(2, 4, 2, 0, 0, 1, 1, 0);
        do_acc(1, 16'h0D01, 16'hD1D1);
        set_cfg(0, 1, 0, 0, 0, 0, 0, 0);
        req_addr = 16'hFFFF; req_wdata = 16'h0000; req_write = 1'b0;
        wait_idle();
        set_cfg(3, 2, 3, 0, 0, 0, 1, 0);
        do_acc(0, 16'h0D02, 0);
        set_cfg(0, 6, 0, 0, 0, 1, 1, 2);
        wait_idle();

        repeat (4) @(posedge clk);
        summary();
    end
endmodule